// File: doc/BRIEF.md
# Pipelined Pixel Capture with Range Classification

This block sits behind a pipelined image digitizer. On every data-valid strobe it captures a pixel code and the converter's out-of-range flag. The code and the flag leave the converter with the same delay, so they always belong to the same sample. The converter's pipeline is `LATENCY` conversions deep. For that reason, the first `LATENCY` strobes after a reset or a frame start carry no real pixel and are thrown away. Every later strobe is tagged with the conversion index it belongs to, counting from 0.

Each kept capture is sorted into one of three classes: in range, overrange or underrange. The sort uses the out-of-range flag together with the code's most significant bit. The result is offered on a valid/ready pixel stream. Two saturating per-frame counters tally the overrange and underrange pixels. If the consumer stalls, the pixel is held. A strobe that arrives while a pixel is held and not accepted is dropped, and a sticky overflow bit is raised.

Control is a three-state machine:
- `ST_FILL` discards pipeline-fill strobes.
- `ST_EMPTY` waits with no pixel held.
- `ST_HOLD` presents a pixel.

The transitions are:
- fill-done: `ST_FILL`→`ST_EMPTY`, on the `LATENCY`-th strobe.
- capture: `ST_EMPTY`→`ST_HOLD`, on a strobe.
- drain: `ST_HOLD`→`ST_EMPTY`, on accept with no strobe.
- refill: any state→`ST_FILL`, on frame start.

`ST_HOLD` stays in `ST_HOLD` when a strobe and an accept come together, or when a strobe arrives during a stall.

Top module: `pcap_top`

## Requirements
- R1: After reset, m_valid, both counters and overflow are 0.
- R2: The first LATENCY data-valid strobes after reset or after frame_start produce no output pixel and are not counted.
- R3: The first kept strobe carries index 0. Each later strobe, whether kept or dropped, advances the index by one.
- R4: m_class is 2'b00 (in range) when the flag is low, whatever the MSB. It is 2'b01 (overrange) when the flag is high and code MSB is 1. It is 2'b10 (underrange) when the flag is high and MSB is 0.
- R5: m_code equals the code presented on the strobe that produced the pixel, and m_valid rises in the cycle after that strobe.
- R6: While m_valid is high and m_ready is low, m_code, m_class and m_index stay stable and m_valid stays high.
- R7: A strobe arriving while a pixel is held and m_ready is low is dropped and sets overflow. overflow then stays set until reset; frame_start does not clear it.
- R8: over_count and under_count add one for each post-fill strobe of their class, including dropped ones, and saturate at 2^CNT_W-1.
- R9: frame_start clears both counters and the index, drops any held pixel (m_valid low next cycle), and restarts the fill.
- R10: A strobe in the same cycle as an accepted pixel loads the new pixel with no gap and does not set overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary pulse |
| dv | input | 1 | Data-valid strobe, one capture per high cycle |
| adc_code | input | CODE_W | Pixel code from the converter |
| adc_oor | input | 1 | Out-of-range flag from the converter |
| m_ready | input | 1 | Consumer ready |
| m_valid | output | 1 | Pixel available |
| m_code | output | CODE_W | Captured pixel code |
| m_class | output | 2 | Range class (00 in, 01 over, 10 under) |
| m_index | output | IDX_W | Conversion index of the pixel |
| over_count | output | CNT_W | Overrange pixels this frame |
| under_count | output | CNT_W | Underrange pixels this frame |
| overflow | output | 1 | Sticky dropped-capture flag |

## Verification
The bench builds the block with LATENCY=4, CODE_W=14, IDX_W=8 and CNT_W=3. The narrow counters saturate at 7, so a handful of overrange strobes is enough to show both reaching and holding the ceiling. The four-strobe fill is exercised twice, once after reset and once after a frame start that also flushes a held pixel. Stall, drop and back-to-back accept cases are covered, and each is checked against the expected pixel index.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    typedef enum logic [1:0] {
        CLS_IN    = 2'b00,
        CLS_OVER  = 2'b01,
        CLS_UNDER = 2'b10
    } pix_class_e;

    typedef enum logic [1:0] {
        ST_FILL  = 2'b00,
        ST_EMPTY = 2'b01,
        ST_HOLD  = 2'b10
    } cap_state_e;
endpackage

// File: rtl/pcap_classify.sv
module pcap_classify
    import pcap_pkg::*;
#(
    parameter int CODE_W = 14
) (
    input  logic [CODE_W-1:0] code,
    input  logic              oor,
    output pix_class_e        cls
);
    localparam int MSB = CODE_W - 1;

    // R4: flag low wins; flag high splits on the MSB
    always_comb begin
        if (!oor)          cls = CLS_IN;
        else if (code[MSB]) cls = CLS_OVER;
        else                cls = CLS_UNDER;
    end
endmodule

// File: rtl/pcap_sat_counter.sv
module pcap_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr)             cnt <= '0;
        else if (inc && cnt != MAX)    cnt <= cnt + 1'b1;
    end

    // R8: a full counter never wraps
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX && !clr) |=> (cnt == MAX));
endmodule

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
    import pcap_pkg::*;
#(
    parameter int CODE_W  = 14,
    parameter int IDX_W   = 16,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              dv,
    input  logic [CODE_W-1:0] code,
    input  pix_class_e        cls,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [CODE_W-1:0] m_code,
    output pix_class_e        m_class,
    output logic [IDX_W-1:0]  m_index,
    output logic              overflow,
    output logic              take
);
    localparam int FILL_W = $clog2(LATENCY + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(LATENCY - 1);

    cap_state_e        state, nxt;
    logic [FILL_W-1:0] fill_cnt;
    logic [IDX_W-1:0]  idx_cnt;
    logic              load, drop;

    assign take = dv && !frame_start && (state != ST_FILL);
    assign load = take && ((state == ST_EMPTY) || m_ready);
    assign drop = take && (state == ST_HOLD) && !m_ready;
    assign m_valid = (state == ST_HOLD);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FILL:  if (dv && fill_cnt == FILL_LAST) nxt = ST_EMPTY;
            ST_EMPTY: if (dv)                          nxt = ST_HOLD;
            ST_HOLD:  if (m_ready && !dv)              nxt = ST_EMPTY;
            default:                                   nxt = ST_FILL;
        endcase
        if (frame_start) nxt = ST_FILL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            idx_cnt  <= '0;
            m_code   <= '0;
            m_class  <= CLS_IN;
            m_index  <= '0;
            overflow <= 1'b0;
        end else begin
            if (frame_start) begin
                fill_cnt <= '0;
                idx_cnt  <= '0;
            end else begin
                if (dv && state == ST_FILL) fill_cnt <= fill_cnt + 1'b1;
                if (take)                   idx_cnt  <= idx_cnt + 1'b1;
            end
            if (load) begin
                m_code  <= code;
                m_class <= cls;
                m_index <= idx_cnt;
            end
            if (drop) overflow <= 1'b1;
        end
    end

    // R6: a stalled pixel is frozen
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !frame_start) |=>
            (m_valid && $stable(m_code) && $stable(m_index) && $stable(m_class)));
    // R7: the overflow bit is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R7: a strobe during a stall raises overflow
    a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && dv && !frame_start) |=> overflow);
    // R9: frame start flushes the held pixel
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !m_valid);
    // R10: accept plus strobe keeps the stream full
    a_r10_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && dv && !frame_start) |=> m_valid);
endmodule

// File: rtl/pcap_top.sv
module pcap_top
    import pcap_pkg::*;
#(
    parameter int CODE_W  = 14,
    parameter int IDX_W   = 16,
    parameter int CNT_W   = 16,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              dv,
    input  logic [CODE_W-1:0] adc_code,
    input  logic              adc_oor,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [CODE_W-1:0] m_code,
    output logic [1:0]        m_class,
    output logic [IDX_W-1:0]  m_index,
    output logic [CNT_W-1:0]  over_count,
    output logic [CNT_W-1:0]  under_count,
    output logic              overflow
);
    localparam int NCNT = 2;

    pix_class_e cls, held_cls;
    logic       take;
    logic [NCNT-1:0] bump;
    logic [CNT_W-1:0] cnts [NCNT];

    pcap_classify #(.CODE_W(CODE_W)) u_cls (
        .code (adc_code),
        .oor  (adc_oor),
        .cls  (cls)
    );

    pcap_ctrl #(.CODE_W(CODE_W), .IDX_W(IDX_W), .LATENCY(LATENCY)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .dv          (dv),
        .code        (adc_code),
        .cls         (cls),
        .m_ready     (m_ready),
        .m_valid     (m_valid),
        .m_code      (m_code),
        .m_class     (held_cls),
        .m_index     (m_index),
        .overflow    (overflow),
        .take        (take)
    );

    assign m_class = held_cls;
    assign bump[0] = take && (cls == CLS_OVER);
    assign bump[1] = take && (cls == CLS_UNDER);

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        pcap_sat_counter #(.W(CNT_W)) u_sat (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (frame_start),
            .inc   (bump[g]),
            .cnt   (cnts[g])
        );
    end

    assign over_count  = cnts[0];
    assign under_count = cnts[1];

    // R4: class 2'b11 never leaves the block
    a_r4_class_legal: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_class != 2'b11));
    // R9: counters restart on a frame boundary
    a_r9_counts_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (over_count == '0 && under_count == '0));
endmodule

// File: tb/sim_pcap_top.sv
module sim_pcap_top;
    localparam int CLK_P   = 10;
    localparam int CODE_W  = 14;
    localparam int IDX_W   = 8;
    localparam int CNT_W   = 3;
    localparam int LATENCY = 4;

    logic clk = 0, rst_n = 0, frame_start = 0, dv = 0, adc_oor = 0, m_ready = 0;
    logic [CODE_W-1:0] adc_code = '0;
    logic m_valid, overflow;
    logic [CODE_W-1:0] m_code;
    logic [1:0] m_class;
    logic [IDX_W-1:0] m_index;
    logic [CNT_W-1:0] over_count, under_count;

    int total = 0, bad = 0, exp_idx = 0;

    always #(CLK_P/2) clk = ~clk;

    pcap_top #(.CODE_W(CODE_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .LATENCY(LATENCY)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dv(dv),
        .adc_code(adc_code), .adc_oor(adc_oor), .m_ready(m_ready),
        .m_valid(m_valid), .m_code(m_code), .m_class(m_class), .m_index(m_index),
        .over_count(over_count), .under_count(under_count), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one strobe cycle; returns at the next negedge with outputs settled
    task automatic strobe(input logic [CODE_W-1:0] c, input logic o);
        @(negedge clk);
        dv = 1; adc_code = c; adc_oor = o;
        @(negedge clk);
        dv = 0;
    endtask

    task automatic t_reset;
        chk("R1 m_valid", m_valid, 0);
        chk("R1 over_count", over_count, 0);
        chk("R1 under_count", under_count, 0);
        chk("R1 overflow", overflow, 0);
    endtask

    task automatic t_fill_after_reset;
        m_ready = 1;
        for (int i = 0; i < LATENCY; i++) begin
            strobe(14'h3FFF, 1'b1);
            chk("R2 fill no pixel", m_valid, 0);
        end
        chk("R2 fill not counted", over_count, 0);
        strobe(14'h1234, 1'b0);
        chk("R5 valid after strobe", m_valid, 1);
        chk("R5 code", m_code, 'h1234);
        chk("R3 first index", m_index, 0);
        chk("R4 in range", m_class, 0);
        exp_idx = 1;
    endtask

    task automatic t_classes;
        strobe(14'h3FFF, 1'b1);
        chk("R4 over class", m_class, 1);
        chk("R3 index", m_index, exp_idx); exp_idx++;
        strobe(14'h0000, 1'b1);
        chk("R4 under class", m_class, 2);
        chk("R3 index", m_index, exp_idx); exp_idx++;
        strobe(14'h2000, 1'b0);
        chk("R4 msb set but flag low", m_class, 0);
        chk("R3 index", m_index, exp_idx); exp_idx++;
        chk("R8 over count", over_count, 1);
        chk("R8 under count", under_count, 1);
    endtask

    task automatic t_back_to_back;
        m_ready = 1;
        @(negedge clk);
        dv = 1; adc_code = 14'h0111; adc_oor = 0;
        @(negedge clk);
        chk("R10 first valid", m_valid, 1);
        chk("R10 first code", m_code, 'h111);
        chk("R10 first index", m_index, exp_idx); exp_idx++;
        adc_code = 14'h0222;
        @(negedge clk);
        dv = 0;
        chk("R10 second valid", m_valid, 1);
        chk("R10 second code", m_code, 'h222);
        chk("R10 second index", m_index, exp_idx); exp_idx++;
        chk("R10 no overflow", overflow, 0);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 6; i++) begin
            strobe(14'h3FFF, 1'b1); exp_idx++;
        end
        chk("R8 reaches max", over_count, 7);
        for (int i = 0; i < 2; i++) begin
            strobe(14'h3FFF, 1'b1); exp_idx++;
        end
        chk("R8 holds max", over_count, 7);
        chk("R8 under untouched", under_count, 1);
    endtask

    task automatic t_stall;
        int a_idx;
        @(negedge clk);
        m_ready = 0;
        strobe(14'h0AAA, 1'b0);
        a_idx = exp_idx; exp_idx++;
        chk("R6 held valid", m_valid, 1);
        repeat (3) @(negedge clk);
        chk("R6 stable valid", m_valid, 1);
        chk("R6 stable code", m_code, 'hAAA);
        chk("R6 overflow clear", overflow, 0);
        strobe(14'h0BBB, 1'b0); exp_idx++;
        chk("R7 overflow set", overflow, 1);
        chk("R7 held code kept", m_code, 'hAAA);
        chk("R7 held index kept", m_index, a_idx);
        m_ready = 1;
        @(negedge clk);
        chk("R6 drained", m_valid, 0);
        strobe(14'h0CCC, 1'b0);
        chk("R3 index skips dropped", m_index, exp_idx); exp_idx++;
    endtask

    task automatic t_frame;
        m_ready = 0;
        strobe(14'h0DDD, 1'b1);
        chk("R9 pre held", m_valid, 1);
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        chk("R9 pixel dropped", m_valid, 0);
        chk("R9 over cleared", over_count, 0);
        chk("R9 under cleared", under_count, 0);
        chk("R7 survives frame", overflow, 1);
        m_ready = 1;
        for (int i = 0; i < LATENCY; i++) begin
            strobe(14'h3FFF, 1'b1);
            chk("R2 frame fill no pixel", m_valid, 0);
        end
        chk("R2 frame fill not counted", over_count, 0);
        strobe(14'h0555, 1'b0);
        chk("R9 restart valid", m_valid, 1);
        chk("R9 index restarts", m_index, 0);
        chk("R5 code after frame", m_code, 'h555);
    endtask

    initial begin
        #(CLK_P * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fill_after_reset();
        t_classes();
        t_back_to_back();
        t_saturate();
        t_stall();
        t_frame();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule